// File: doc/BRIEF.md
# Receive Interrupt Coalescing Controller

This block sits beside a network receive path and decides when the host gets a receive interrupt. Rather than interrupting for every completed frame, it collects frames into a bundle. The bundle is flushed with a single interrupt when it reaches a configured size, or when a dead-man timer started by the first frame of the bundle runs out. Frames whose length is short, as judged by a length mask, interrupt at once and leave the pending bundle alone. This gets small acknowledgement frames to the host without delay.

The receive path pulses `frame_done` with the frame length. A free-running `tick` paces the timer. Three 16-bit settings are held steady during operation: the timer reload value (0x600 is typical, sensible values range from 0x200 to 0x1000), the bundle size limit (typically 6) and the short-frame mask (typically 0xFF80, so frames of 127 bytes or less are short). The output is a one-cycle interrupt pulse, plus the number of bundled frames that pulse flushes.

Top module: `rx_irq_coalescer`

## Requirements
- R1: A synchronous reset, while asserted and on the first cycle after it, holds `irq` low and `irq_count` at 0. It empties the bundle and stops the timer, so ticks after reset raise nothing.
- R2: A frame is short when `frame_len & cfg_len_mask` is zero. A short frame raises `irq` on the cycle after `frame_done`, with `irq_count` equal to 0 unless a bundle flush coincides.
- R3: A short frame does not change the pending bundle. Its frame count and its running timer carry on as if the short frame had not arrived.
- R4: A frame that is not short joins the bundle. When the bundle count, including the frame of this cycle, reaches `cfg_max_count`, `irq` rises on the next cycle with `irq_count` equal to that count. A limit of 0 acts as 1.
- R5: A limit of 1 makes every bundled frame raise its own interrupt with `irq_count` 1. A limit of 0xFFFF lets a bundle hold up to 65535 frames before the count alone flushes it.
- R6: The first frame into an empty bundle loads the timer with `cfg_reload`, and a tick in that cycle is ignored. Each later tick decrements the timer. On the tick that brings it to zero, the bundle flushes with `irq` on the next cycle and `irq_count` set to the pending count. A reload of 0 behaves as 1.
- R7: After any bundle flush the count is zero and the timer is stopped. Ticks alone then raise no interrupt until a new bundled frame arrives. A cycle with neither a frame nor a tick never produces `irq` on the following cycle.
- R8: When the size limit and timer expiry hit in the same cycle, exactly one one-cycle pulse is produced, reporting the frames pending in that cycle. `irq_count` is 0 whenever `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_done | input | 1 | One-cycle strobe: a frame has been received |
| frame_len | input | 16 | Length in bytes of the frame flagged by `frame_done` |
| tick | input | 1 | Timer time base, one decrement per pulse |
| cfg_reload | input | 16 | Dead-man timer reload value |
| cfg_max_count | input | 16 | Bundle size limit |
| cfg_len_mask | input | 16 | Short-frame length mask |
| irq | output | 1 | One-cycle receive interrupt request |
| irq_count | output | 16 | Bundled frames flushed by this interrupt; 0 when `irq` is low |

## Verification
The bench places a short frame inside a live bundle. It checks that the later size-limit flush still reports the full count, and that the timer still expires on its original tick. A design that cleared or restarted the bundle on a short frame would interrupt late or report too few frames. It lines the limit and the timer expiry up on one cycle. A design that raised two pulses, or let the timer keep running after the flush, would show a second interrupt. It also covers a limit of 1, a near-unlimited limit, masks of 0xFFFF and 0xF800, the 127/128-byte boundary, and reset in the middle of a bundle. A design that kept stale count after reset would flush early.

// File: rtl/rx_coal_pkg.sv
package rx_coal_pkg;
    parameter int unsigned CFG_W = 16;

    typedef logic [CFG_W-1:0] cfg_word_t;

    typedef struct packed {
        cfg_word_t pending;
        logic      irq;
        cfg_word_t flushed;
    } coal_state_t;

    typedef struct packed {
        logic      running;
        cfg_word_t remain;
    } deadman_state_t;
endpackage

// File: rtl/rx_len_filter.sv
module rx_len_filter
    import rx_coal_pkg::*;
(
    input  logic      frame_done,
    input  cfg_word_t frame_len,
    input  cfg_word_t len_mask,
    output logic      is_short,
    output logic      is_bundled
);
    logic masked_zero;

    always_comb begin
        masked_zero = ((frame_len & len_mask) == '0);
        is_short    = frame_done && masked_zero;
        is_bundled  = frame_done && !masked_zero;
    end
endmodule

// File: rtl/rx_deadman_timer.sv
module rx_deadman_timer
    import rx_coal_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      flush,
    input  logic      tick,
    input  cfg_word_t reload,
    output logic      expire
);
    deadman_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        expire = st_q.running && tick && !start && (st_q.remain <= cfg_word_t'(1));
        if (flush) begin
            st_d.running = 1'b0;
            st_d.remain  = '0;
        end else if (start) begin
            st_d.running = 1'b1;
            st_d.remain  = reload;
        end else if (st_q.running && tick) begin
            st_d.remain  = st_q.remain - cfg_word_t'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/rx_irq_coalescer.sv
module rx_irq_coalescer
    import rx_coal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_done,
    input  logic [CFG_W-1:0]  frame_len,
    input  logic              tick,
    input  logic [CFG_W-1:0]  cfg_reload,
    input  logic [CFG_W-1:0]  cfg_max_count,
    input  logic [CFG_W-1:0]  cfg_len_mask,
    output logic              irq,
    output logic [CFG_W-1:0]  irq_count
);
    coal_state_t st_d, st_q;
    logic        short_frm;
    logic        bundled_frm;
    logic        timer_expire;
    logic        bundle_start;
    logic        limit_hit;
    logic        flush;
    cfg_word_t   pending_next;
    cfg_word_t   limit_eff;

    rx_len_filter u_filter (
        .frame_done (frame_done),
        .frame_len  (frame_len),
        .len_mask   (cfg_len_mask),
        .is_short   (short_frm),
        .is_bundled (bundled_frm)
    );

    rx_deadman_timer u_timer (
        .clk    (clk),
        .rst    (rst),
        .start  (bundle_start),
        .flush  (flush),
        .tick   (tick),
        .reload (cfg_reload),
        .expire (timer_expire)
    );

    always_comb begin
        limit_eff    = (cfg_max_count == '0) ? cfg_word_t'(1) : cfg_max_count;
        pending_next = st_q.pending + cfg_word_t'(bundled_frm);
        bundle_start = bundled_frm && (st_q.pending == '0);
        limit_hit    = bundled_frm && (pending_next >= limit_eff);
        flush        = limit_hit || timer_expire;

        st_d         = st_q;
        st_d.irq     = flush || short_frm;
        st_d.flushed = flush ? pending_next : '0;
        st_d.pending = flush ? '0 : pending_next;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq       = st_q.irq;
    assign irq_count = st_q.flushed;
endmodule

// File: rtl/rx_irq_coalescer_chk.sv
module rx_irq_coalescer_chk
    import rx_coal_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      frame_done,
    input cfg_word_t frame_len,
    input logic      tick,
    input cfg_word_t cfg_max_count,
    input cfg_word_t cfg_len_mask,
    input logic      irq,
    input cfg_word_t irq_count
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!irq && irq_count == '0));

    assert_short_fires_R2: assert property (@(posedge clk) disable iff (rst)
        (frame_done && ((frame_len & cfg_len_mask) == '0)) |=> irq);

    assert_single_frame_R5: assert property (@(posedge clk) disable iff (rst)
        (frame_done && ((frame_len & cfg_len_mask) != '0) && cfg_max_count == 16'd1)
        |=> (irq && irq_count != '0));

    assert_quiet_idle_R7: assert property (@(posedge clk) disable iff (rst)
        (!frame_done && !tick) |=> !irq);

    assert_count_zero_R8: assert property (@(posedge clk) disable iff (rst)
        !irq |-> (irq_count == '0));
endmodule

bind rx_irq_coalescer rx_irq_coalescer_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .frame_done    (frame_done),
    .frame_len     (frame_len),
    .tick          (tick),
    .cfg_max_count (cfg_max_count),
    .cfg_len_mask  (cfg_len_mask),
    .irq           (irq),
    .irq_count     (irq_count)
);

// File: tb/rx_irq_coalescer_test.sv
module rx_irq_coalescer_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_done = 1'b0;
    logic [15:0] frame_len = '0;
    logic        tick = 1'b0;
    logic [15:0] cfg_reload = 16'h0600;
    logic [15:0] cfg_max_count = 16'd6;
    logic [15:0] cfg_len_mask = 16'hFF80;
    logic        irq;
    logic [15:0] irq_count;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_irq_coalescer uut (
        .clk(clk), .rst(rst), .frame_done(frame_done), .frame_len(frame_len),
        .tick(tick), .cfg_reload(cfg_reload), .cfg_max_count(cfg_max_count),
        .cfg_len_mask(cfg_len_mask), .irq(irq), .irq_count(irq_count)
    );

    task automatic expect_out(input string req, input logic exp_irq, input logic [15:0] exp_cnt);
        checks++;
        if (irq !== exp_irq || irq_count !== exp_cnt) begin
            fails++;
            $display("FAIL %s: irq=%0b count=%0d, expected irq=%0b count=%0d",
                     req, irq, irq_count, exp_irq, exp_cnt);
        end
    endtask

    // one cycle of stimulus; outputs sampled just after the edge reflect it
    task automatic cyc(input logic fd, input logic [15:0] len, input logic tk);
        frame_done = fd;
        frame_len  = len;
        tick       = tk;
        @(posedge clk);
        #1;
        frame_done = 1'b0;
        tick       = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        cyc(0, 0, 0);
        cyc(0, 0, 0);
        rst = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        expect_out("R1 reset state", 1'b0, 16'd0);
    endtask

    task automatic t_limit_six();
        do_reset();
        cfg_max_count = 16'd6; cfg_len_mask = 16'hFF80;
        for (int i = 0; i < 5; i++) cyc(1, 16'd200, 0);
        expect_out("R4 below limit", 1'b0, 16'd0);
        cyc(1, 16'd128, 0);
        expect_out("R4 limit reached (128-byte frame bundled)", 1'b1, 16'd6);
        cyc(0, 0, 0);
        expect_out("R8 pulse one cycle", 1'b0, 16'd0);
    endtask

    task automatic t_limit_one();
        do_reset();
        cfg_max_count = 16'd1;
        cyc(1, 16'd300, 0);
        expect_out("R5 limit 1 first", 1'b1, 16'd1);
        cyc(1, 16'd300, 0);
        expect_out("R5 limit 1 second", 1'b1, 16'd1);
        cfg_max_count = 16'd6;
    endtask

    task automatic t_short_keeps_count();
        do_reset();
        cfg_max_count = 16'd6; cfg_len_mask = 16'hFF80;
        cyc(1, 16'd500, 0);
        cyc(1, 16'd500, 0);
        cyc(1, 16'd127, 0);
        expect_out("R2 127-byte short frame", 1'b1, 16'd0);
        for (int i = 0; i < 3; i++) cyc(1, 16'd500, 0);
        expect_out("R3 count kept, not yet full", 1'b0, 16'd0);
        cyc(1, 16'd500, 0);
        expect_out("R3 count kept across short frame", 1'b1, 16'd6);
    endtask

    task automatic t_short_keeps_timer();
        do_reset();
        cfg_reload = 16'd4; cfg_max_count = 16'd6;
        cyc(1, 16'd400, 1);
        cyc(0, 0, 1);
        cyc(0, 0, 1);
        cyc(1, 16'd60, 0);
        expect_out("R2 short during timer", 1'b1, 16'd0);
        cyc(0, 0, 1);
        expect_out("R3 timer not restarted", 1'b0, 16'd0);
        cyc(0, 0, 1);
        expect_out("R3 timer expires on original tick", 1'b1, 16'd1);
    endtask

    task automatic t_timer_expiry();
        do_reset();
        cfg_reload = 16'd3; cfg_max_count = 16'd6;
        cyc(1, 16'd900, 0);
        cyc(1, 16'd900, 1);
        cyc(0, 0, 1);
        expect_out("R6 before expiry", 1'b0, 16'd0);
        cyc(0, 0, 1);
        expect_out("R6 expiry flush", 1'b1, 16'd2);
        for (int i = 0; i < 5; i++) cyc(0, 0, 1);
        expect_out("R7 timer stopped after flush", 1'b0, 16'd0);
    endtask

    task automatic t_coincide();
        do_reset();
        cfg_reload = 16'd2; cfg_max_count = 16'd3;
        cyc(1, 16'd256, 0);
        cyc(1, 16'd256, 1);
        cyc(1, 16'd256, 1);
        expect_out("R8 limit and expiry together", 1'b1, 16'd3);
        cyc(0, 0, 1);
        expect_out("R8 single pulse", 1'b0, 16'd0);
        cyc(0, 0, 1);
        expect_out("R7 no late expiry", 1'b0, 16'd0);
    endtask

    task automatic t_masks();
        do_reset();
        cfg_reload = 16'h0600; cfg_max_count = 16'd6;
        cfg_len_mask = 16'hFFFF;
        cyc(1, 16'd1, 0);
        expect_out("R2 mask FFFF bundles 1-byte frame", 1'b0, 16'd0);
        cfg_len_mask = 16'hF800;
        cyc(1, 16'd2047, 0);
        expect_out("R2 mask F800 short 2047", 1'b1, 16'd0);
        cfg_len_mask = 16'hFF80;
    endtask

    task automatic t_no_limit();
        do_reset();
        cfg_max_count = 16'hFFFF;
        for (int i = 0; i < 20; i++) cyc(1, 16'd1500, 0);
        expect_out("R5 limit FFFF holds 20 frames", 1'b0, 16'd0);
        cfg_max_count = 16'd6;
    endtask

    task automatic t_reset_mid();
        do_reset();
        cfg_reload = 16'd2; cfg_max_count = 16'd6;
        for (int i = 0; i < 3; i++) cyc(1, 16'd700, 0);
        do_reset();
        cyc(0, 0, 1);
        cyc(0, 0, 1);
        expect_out("R1 timer stopped by reset", 1'b0, 16'd0);
        cfg_reload = 16'h0600;
        for (int i = 0; i < 5; i++) cyc(1, 16'd700, 0);
        expect_out("R1 count cleared by reset", 1'b0, 16'd0);
        cyc(1, 16'd700, 0);
        expect_out("R1 fresh bundle of 6", 1'b1, 16'd6);
    endtask

    task automatic t_idle_ticks();
        do_reset();
        cfg_reload = 16'd1;
        for (int i = 0; i < 4; i++) cyc(0, 0, 1);
        expect_out("R7 ticks on empty bundle", 1'b0, 16'd0);
    endtask

    initial begin
        t_reset_state();
        t_limit_six();
        t_limit_one();
        t_short_keeps_count();
        t_short_keeps_timer();
        t_timer_expiry();
        t_coincide();
        t_masks();
        t_no_limit();
        t_reset_mid();
        t_idle_ticks();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: run did not complete, expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule